// File: doc/BRIEF.md
# SPI flash phase sequencer

This block runs a single serial-flash transaction on its own. The caller sets up three configuration words and an address word, then writes the request word with its start bit set. The engine lowers chip select and steps through up to five phases in a fixed order: opcode, address, dummy clocks, outgoing data and incoming data. Each phase has its own enable and its own lane code, which selects 1, 2 or 4 IO lines. When the last phase is over, the engine releases chip select and reports completion in the request word.

Outgoing data bytes come from a local byte buffer, starting at index 0. Incoming bytes are stored into the same buffer, also starting at index 0. The caller fills and reads the buffer through a byte port while the engine is idle. The serial clock runs at the system clock divided by twice the `HALF` parameter. Data is launched while SCK is low and sampled at the end of SCK high. Within a lane group bits leave most significant first, and address bytes leave most significant byte first.

Top module: `sfl_seq`

## Requirements
- R1: A write to the request word with bit 31 set while idle starts a transaction. One cycle after the write edge, chip select is low, SCK is low, no IO line is driven, bit 31 reads 1, and bits 30 and 0 read 0.
- R2: The cycle after the start is a lead cycle. Then each enabled phase runs in the order opcode, address, dummy, write data, read data. Every serial clock takes 2*HALF cycles: HALF with SCK low, then HALF with SCK high. After the last clock comes one tail cycle with chip select still low and SCK low.
- R3: The opcode phase is enabled by bit 30 of the main word and sends bits 27:20. Bits 29:28 give the lane code. A single-lane bit goes on io[0]. In dual mode the higher bit of each pair goes on io[1]. In quad mode the higher nibble goes first on io[3:0].
- R4: Lane code 0 selects 1 line, code 1 selects 2 lines and codes 2 and 3 select 4 lines. In a driven phase io_oe is 0001, 0011 or 1111 to match.
- R5: The address phase is enabled by bit 19 of the main word, with lane code in bits 18:17. Bits 16:15 hold the byte count minus one. The bytes are the low bytes of the address word, sent most significant first.
- R6: The dummy phase is enabled by bit 31 of the dummy word, with lane code in bits 30:29. Bits 28:23 give the number of dummy clocks, and a count of zero skips the phase. If a read phase with 2 or 4 lanes follows, all IO lines are released during the dummy clocks. Otherwise the dummy phase's own lanes drive 0.
- R7: The write phase is enabled by bit 14 of the main word, with lane code in bits 11:10. Bits 9:0 give the byte count, and a count of zero skips the phase. Counts above 512 are cut to 512. Bytes are taken from buffer index 0 upward.
- R8: The read phase is enabled by bit 31 of the read word, with lane code in bits 28:27 and byte count in bits 25:16. Zero skips the phase and counts above 512 are cut to 512. Single-lane reads sample io[1] while io[0] is driven to 0. Dual reads sample io[1:0] and quad reads sample io[3:0], with every line released. Bytes are stored from buffer index 0 upward.
- R9: The cycle after the tail cycle, chip select is high, bit 31 reads 0 and bit 30 reads 1. Bit 0 reads 1 exactly when a read phase ran.
- R10: A request write while a transaction runs has no effect on the serial stream or on the completion time.
- R11: With no phase enabled, the transaction is a lead cycle and a tail cycle with no SCK edge. Completion follows two cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Request word write strobe |
| ctl_wdata | input | 32 | Request write data (bit 31 = start) |
| ctl_status | output | 32 | Request word: bit 31 busy, bit 30 finished, bit 0 read data stored |
| cfg_main | input | 32 | Opcode, address and write-data phase settings |
| cfg_dummy | input | 32 | Dummy phase settings |
| cfg_din | input | 32 | Read phase settings |
| cfg_addr | input | 32 | Address value |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_addr | input | 9 | Buffer byte index |
| buf_wdata | input | 8 | Buffer write byte |
| buf_rdata | output | 8 | Buffer byte at buf_addr |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| io_out | output | 4 | IO line output values |
| io_oe | output | 4 | IO line output enables |
| io_in | input | 4 | IO line input values |

## Verification
The start edge gives the lead cycle one cycle later. Serial clock s then occupies cycles 1+2*HALF*s through 2*HALF*(s+1) after that edge. With N clocks in total, the tail cycle is due 1+2*HALF*N cycles after the start edge and completion 2+2*HALF*N cycles after it. The bench turns each transaction into a per-cycle list of expected chip select, SCK, enables, output values and request bits. It compares the list against the design at every falling edge, and it changes io_in at those same falling edges, so each sampled value is steady at the edge that ends its slot. Buffer contents are compared after completion, through the byte port.

// File: rtl/sfl_seq.sv
`timescale 1ns/1ps
module sfl_seq #(
  parameter int HALF = 2,
  parameter int BUF_DEPTH = 512,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_status,
  input  logic [31:0]   cfg_main,
  input  logic [31:0]   cfg_dummy,
  input  logic [31:0]   cfg_din,
  input  logic [31:0]   cfg_addr,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  input  logic [3:0]    io_in
);
  localparam int LW = 10;
  localparam logic [LW-1:0] MAXN = LW'(BUF_DEPTH);
  localparam logic [HW-1:0] HLAST = HW'(HALF - 1);

  typedef enum logic [2:0] {P_IDLE, P_LEAD, P_CMD, P_ADDR, P_DMY, P_WR, P_RD, P_TAIL} ph_t;

  ph_t ph, ph_next;
  logic [HW-1:0] hcnt;
  logic [2:0]    grp;
  logic [LW-1:0] idx;
  logic [7:0]    rxsh;
  logic          fin, upd;
  logic [7:0]    mem [BUF_DEPTH];

  logic          cmd_en, adr_en, wr_en, dmy_en, rd_en;
  logic [1:0]    cmd_ln, adr_ln, wr_ln, dmy_ln, rd_ln, adr_nb;
  logic [7:0]    opc;
  logic [LW-1:0] wr_len, rd_len;
  logic [5:0]    dmy_cyc;

  assign cmd_en  = cfg_main[30];
  assign cmd_ln  = cfg_main[29:28];
  assign opc     = cfg_main[27:20];
  assign adr_en  = cfg_main[19];
  assign adr_ln  = cfg_main[18:17];
  assign adr_nb  = cfg_main[16:15];
  assign wr_en   = cfg_main[14];
  assign wr_ln   = cfg_main[11:10];
  assign wr_len  = cfg_main[9:0];
  assign dmy_en  = cfg_dummy[31];
  assign dmy_ln  = cfg_dummy[30:29];
  assign dmy_cyc = cfg_dummy[28:23];
  assign rd_en   = cfg_din[31];
  assign rd_ln   = cfg_din[28:27];
  assign rd_len  = cfg_din[25:16];

  logic unused_bits;
  assign unused_bits = ^{ctl_wdata[30:0], cfg_main[31], cfg_main[13:12], cfg_dummy[22:0],
                         cfg_din[30:29], cfg_din[26], cfg_din[15:0]};

  logic [7:0] en;
  assign en = {1'b1, rd_en && rd_len != '0, wr_en && wr_len != '0,
               dmy_en && dmy_cyc != '0, adr_en, cmd_en, 2'b00};

  always_comb begin
    ph_next = P_TAIL;
    for (int i = 6; i >= 2; i--)
      if (en[i] && 3'(i) > ph) ph_next = ph_t'(3'(i));
  end

  function automatic logic [3:0] lmask(input logic [1:0] c);
    case (c)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  logic [1:0]    cur_ln;
  logic [LW-1:0] cur_nb;
  always_comb begin
    case (ph)
      P_CMD:   begin cur_ln = cmd_ln; cur_nb = LW'(1); end
      P_ADDR:  begin cur_ln = adr_ln; cur_nb = {8'b0, adr_nb} + LW'(1); end
      P_DMY:   begin cur_ln = dmy_ln; cur_nb = {4'b0, dmy_cyc}; end
      P_WR:    begin cur_ln = wr_ln;  cur_nb = (wr_len > MAXN) ? MAXN : wr_len; end
      P_RD:    begin cur_ln = rd_ln;  cur_nb = (rd_len > MAXN) ? MAXN : rd_len; end
      default: begin cur_ln = 2'd0;   cur_nb = LW'(1); end
    endcase
  end

  logic [2:0] last_grp;
  assign last_grp = (ph == P_DMY) ? 3'd0 : (cur_ln == 2'd0) ? 3'd7 : (cur_ln == 2'd1) ? 3'd3 : 3'd1;

  logic [1:0] asel;
  logic [7:0] abyte, cb, sh8;
  logic [3:0] shamt, drv, oe_c;
  assign asel = adr_nb - idx[1:0];
  always_comb begin
    case (asel)
      2'd0:    abyte = cfg_addr[7:0];
      2'd1:    abyte = cfg_addr[15:8];
      2'd2:    abyte = cfg_addr[23:16];
      default: abyte = cfg_addr[31:24];
    endcase
  end

  always_comb begin
    case (ph)
      P_CMD:   cb = opc;
      P_ADDR:  cb = abyte;
      P_WR:    cb = mem[idx[AW-1:0]];
      default: cb = 8'h00;
    endcase
  end

  assign shamt = (cur_ln == 2'd0) ? {1'b0, grp} : (cur_ln == 2'd1) ? {grp, 1'b0} : {grp[1:0], 2'b00};
  assign sh8   = cb << shamt;
  assign drv   = (cur_ln == 2'd0) ? {3'b000, sh8[7]} : (cur_ln == 2'd1) ? {2'b00, sh8[7:6]} : sh8[7:4];

  logic rd_multi;
  assign rd_multi = en[6] && rd_ln != 2'd0;

  always_comb begin
    case (ph)
      P_CMD, P_ADDR, P_WR: oe_c = lmask(cur_ln);
      P_DMY:               oe_c = rd_multi ? 4'b0000 : lmask(dmy_ln);
      P_RD:                oe_c = (rd_ln == 2'd0) ? 4'b0001 : 4'b0000;
      default:             oe_c = 4'b0000;
    endcase
  end

  assign io_oe  = oe_c;
  assign io_out = (ph == P_CMD || ph == P_ADDR || ph == P_WR) ? (drv & oe_c) : 4'b0000;

  logic shifting, slot_end, grp_end, byte_end, eng_we;
  logic [7:0] asm_b;
  assign shifting = (ph == P_CMD) || (ph == P_ADDR) || (ph == P_DMY) || (ph == P_WR) || (ph == P_RD);
  assign slot_end = shifting && hcnt == HLAST && spi_sck;
  assign grp_end  = grp == last_grp;
  assign byte_end = idx == cur_nb - LW'(1);
  assign asm_b    = (rd_ln == 2'd0) ? {rxsh[6:0], io_in[1]} :
                    (rd_ln == 2'd1) ? {rxsh[5:0], io_in[1:0]} : {rxsh[3:0], io_in};
  assign eng_we   = slot_end && ph == P_RD && grp_end;

  always_ff @(posedge clk) begin
    if (eng_we) mem[idx[AW-1:0]] <= asm_b;
    else if (buf_we) mem[buf_addr] <= buf_wdata;
  end
  assign buf_rdata = mem[buf_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; spi_cs_n <= 1'b1; spi_sck <= 1'b0; hcnt <= '0;
      grp <= '0; idx <= '0; rxsh <= '0; fin <= 1'b0; upd <= 1'b0;
    end else begin
      case (ph)
        P_IDLE: if (ctl_wr && ctl_wdata[31]) begin
          ph <= P_LEAD; spi_cs_n <= 1'b0; fin <= 1'b0; upd <= 1'b0;
        end
        P_LEAD: begin
          ph <= ph_next; grp <= '0; idx <= '0; hcnt <= '0; spi_sck <= 1'b0;
        end
        P_TAIL: begin
          ph <= P_IDLE; spi_cs_n <= 1'b1; fin <= 1'b1; upd <= en[6];
        end
        default: begin
          if (hcnt != HLAST) hcnt <= hcnt + HW'(1);
          else begin
            hcnt <= '0;
            spi_sck <= ~spi_sck;
            if (spi_sck) begin
              if (ph == P_RD) rxsh <= asm_b;
              if (!grp_end) grp <= grp + 3'd1;
              else begin
                grp <= '0;
                if (byte_end) begin idx <= '0; ph <= ph_next; end
                else idx <= idx + LW'(1);
              end
            end
          end
        end
      endcase
    end
  end

  assign ctl_status = {ph != P_IDLE, fin, 29'b0, upd};

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_status[31]) |-> !spi_cs_n && !ctl_status[30] && !ctl_status[0]);
  p_sck_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n && ctl_status[31]);
  p_hold_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(io_out) && $stable(io_oe));
  p_oe_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111);
  p_undriven_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out & ~io_oe) == 4'b0000);
  p_finish_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_status[30]) |-> spi_cs_n && !ctl_status[31] && $past(!spi_cs_n));
  p_upd_with_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_status[0] |-> ctl_status[30]);
endmodule

// File: tb/sfl_seq_bench.sv
`timescale 1ns/1ps
module sfl_seq_bench;
  localparam int H = 2;
  localparam int DEPTH = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = 32'h8000_0000;
  logic [31:0] ctl_status;
  logic [31:0] cfg_main = '0, cfg_dummy = '0, cfg_din = '0, cfg_addr = '0;
  logic buf_we = 1'b0;
  logic [8:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic spi_cs_n, spi_sck;
  logic [3:0] io_out, io_oe, io_in = '0;

  always #4 clk = ~clk;

  sfl_seq #(.HALF(H), .BUF_DEPTH(DEPTH)) u_sfl_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_status(ctl_status),
    .cfg_main(cfg_main), .cfg_dummy(cfg_dummy), .cfg_din(cfg_din), .cfg_addr(cfg_addr),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  typedef struct packed {
    logic cs; logic sck; logic [3:0] oe; logic [3:0] out; logic [3:0] din; logic [2:0] st;
  } exp_t;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] bufm [DEPTH];
  exp_t eq[$];
  string tq[$];
  logic [3:0] s_oe[$], s_out[$], s_din[$];
  string s_tag[$];
  logic last_fin = 1'b0, last_upd = 1'b0;

  function automatic int lanes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] lmask(input logic [1:0] c);
    return (c == 2'd0) ? 4'b0001 : (c == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic int clampn(input int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  function automatic logic [31:0] mk_main(input bit ce, input logic [1:0] cl, input logic [7:0] op,
      input bit ae, input logic [1:0] al, input int anb, input bit we, input logic [1:0] wl, input int wn);
    logic [31:0] w = '0;
    w[30] = ce; w[29:28] = cl; w[27:20] = op;
    w[19] = ae; w[18:17] = al; w[16:15] = 2'(anb - 1);
    w[14] = we; w[11:10] = wl; w[9:0] = 10'(wn);
    return w;
  endfunction

  function automatic logic [31:0] mk_dmy(input bit e, input logic [1:0] l, input int cyc);
    logic [31:0] w = '0;
    w[31] = e; w[30:29] = l; w[28:23] = 6'(cyc);
    return w;
  endfunction

  function automatic logic [31:0] mk_din(input bit e, input logic [1:0] l, input int n);
    logic [31:0] w = '0;
    w[31] = e; w[28:27] = l; w[25:16] = 10'(n);
    return w;
  endfunction

  task automatic add_slot(input logic [3:0] oe, input logic [3:0] out, input logic [3:0] din, input string t);
    s_oe.push_back(oe); s_out.push_back(out); s_din.push_back(din); s_tag.push_back(t);
  endtask

  task automatic add_byte(input logic [7:0] b, input logic [1:0] c, input string t);
    int L = lanes(c);
    for (int g = 0; g < 8 / L; g++) begin
      int v = (int'(b) >> (8 - L * (g + 1))) & ((1 << L) - 1);
      add_slot(lmask(c), 4'(v), 4'b0, t);
    end
  endtask

  task automatic push_exp(input logic cs, input logic sck, input logic [3:0] oe, input logic [3:0] out,
                          input logic [3:0] din, input logic [2:0] st, input string t);
    exp_t e;
    e.cs = cs; e.sck = sck; e.oe = oe; e.out = out; e.din = din; e.st = st;
    eq.push_back(e); tq.push_back(t);
  endtask

  task automatic run(input logic [31:0] wm, input logic [31:0] wd, input logic [31:0] wr,
                     input logic [31:0] wa, input int poke);
    int nw, nr, anb;
    bit rd_ran, rmulti;
    string tail_t, fin_t;
    s_oe.delete(); s_out.delete(); s_din.delete(); s_tag.delete(); eq.delete(); tq.delete();
    nw = clampn(int'(wm[9:0]));
    nr = clampn(int'(wr[25:16]));
    rd_ran = wr[31] && nr > 0;
    rmulti = rd_ran && wr[28:27] != 2'd0;
    if (wm[30]) add_byte(wm[27:20], wm[29:28], (wm[29:28] != 2'd0) ? "R4" : "R3");
    if (wm[19]) begin
      anb = int'(wm[16:15]) + 1;
      for (int b = 0; b < anb; b++) add_byte(8'(wa >> (8 * (anb - 1 - b))), wm[18:17], "R5");
    end
    if (wd[31] && wd[28:23] != 6'd0)
      for (int c = 0; c < int'(wd[28:23]); c++)
        add_slot(rmulti ? 4'b0000 : lmask(wd[30:29]), 4'b0, 4'b0, "R6");
    if (wm[14] && nw > 0)
      for (int i = 0; i < nw; i++) add_byte(bufm[i], wm[11:10], "R7");
    if (rd_ran) begin
      int L = lanes(wr[28:27]);
      for (int i = 0; i < nr; i++) begin
        int acc = 0;
        for (int g = 0; g < 8 / L; g++) begin
          logic [3:0] d = 4'($urandom);
          int bits = (L == 1) ? int'(d[1]) : (L == 2) ? int'(d[1:0]) : int'(d);
          acc = (acc << L) | bits;
          add_slot((L == 1) ? 4'b0001 : 4'b0000, 4'b0, d, "R8");
        end
        bufm[i] = 8'(acc);
      end
    end
    tail_t = (s_oe.size() == 0) ? "R11" : "R2";
    fin_t  = (poke > 0) ? "R10" : (s_oe.size() == 0) ? "R11" : "R9";
    push_exp(1'b0, 1'b0, 4'b0, 4'b0, 4'b0, 3'b100, "R1");
    for (int s = 0; s < s_oe.size(); s++)
      for (int c = 0; c < 2 * H; c++)
        push_exp(1'b0, c >= H, s_oe[s], s_out[s], s_din[s], 3'b100, s_tag[s]);
    push_exp(1'b0, 1'b0, 4'b0, 4'b0, 4'b0, 3'b100, tail_t);
    push_exp(1'b1, 1'b0, 4'b0, 4'b0, 4'b0, {2'b01, rd_ran}, fin_t);
    push_exp(1'b1, 1'b0, 4'b0, 4'b0, 4'b0, {2'b01, rd_ran}, fin_t);

    @(negedge clk);
    cfg_main = wm; cfg_dummy = wd; cfg_din = wr; cfg_addr = wa;
    ctl_wr = 1'b1;
    for (int k = 0; k < eq.size(); k++) begin
      logic [12:0] act, expv;
      @(negedge clk);
      ctl_wr = (k == poke);
      act  = {spi_cs_n, spi_sck, io_oe, io_out, ctl_status[31], ctl_status[30], ctl_status[0]};
      expv = {eq[k].cs, eq[k].sck, eq[k].oe, eq[k].out, eq[k].st};
      checks++;
      if (act !== expv) begin
        errors++;
        $display("FAIL %s cycle %0d: actual=%b expected=%b", tq[k], k, act, expv);
      end
      io_in = eq[k].din;
    end
    ctl_wr = 1'b0;
    io_in = 4'b0;
    last_fin = 1'b1; last_upd = rd_ran;
    check_buf();
  endtask

  task automatic check_buf();
    int bad = 0;
    logic [7:0] a0 = 8'h00, e0 = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      buf_addr = 9'(i);
      #1;
      if (buf_rdata !== bufm[i]) begin
        if (bad == 0) begin a0 = buf_rdata; e0 = bufm[i]; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R8 buffer (%0d bytes differ): actual=%h expected=%h", bad, a0, e0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({spi_cs_n, spi_sck, io_oe, io_out, ctl_status} !== {1'b1, 1'b0, 8'h00, 32'h0}) begin
      errors++;
      $display("FAIL R1 reset state: actual=%b expected=%b",
               {spi_cs_n, spi_sck, io_oe, io_out, ctl_status}, {1'b1, 1'b0, 8'h00, 32'h0});
    end
    for (int i = 0; i < DEPTH; i++) begin
      buf_we = 1'b1; buf_addr = 9'(i); buf_wdata = 8'((i * 37 + 5) & 255);
      bufm[i] = 8'((i * 37 + 5) & 255);
      @(negedge clk);
    end
    buf_we = 1'b0;

    // R11: nothing enabled
    run(32'h0, 32'h0, 32'h0, 32'h0, -1);
    // R3: opcode alone, single lane
    run(mk_main(1, 2'd0, 8'h06, 0, 2'd0, 1, 0, 2'd0, 0), 32'h0, 32'h0, 32'h0, -1);
    // R3 R8: opcode then single-lane read
    run(mk_main(1, 2'd0, 8'h9F, 0, 2'd0, 1, 0, 2'd0, 0), 32'h0, mk_din(1, 2'd0, 3), 32'h0, -1);
    // R5 R6 R8: quad address, dummy released before quad read
    run(mk_main(1, 2'd0, 8'hEB, 1, 2'd2, 3, 0, 2'd0, 0), mk_dmy(1, 2'd2, 6),
        mk_din(1, 2'd2, 16), 32'h00A1B2C3, -1);
    // R4 R5 R6: dual opcode, four address bytes, single dummy before dual read
    run(mk_main(1, 2'd1, 8'hBB, 1, 2'd1, 4, 0, 2'd0, 0), mk_dmy(1, 2'd0, 8),
        mk_din(1, 2'd1, 5), 32'h12345678, -1);
    // R7: quad write from buffer
    run(mk_main(1, 2'd0, 8'h32, 1, 2'd0, 3, 1, 2'd2, 9), 32'h0, 32'h0, 32'h00FEDCBA, -1);
    // R4 R6 R7 R8: lane code 3, zero-count dummy skipped, write then read
    run(mk_main(1, 2'd3, 8'h5A, 0, 2'd0, 1, 1, 2'd1, 2), mk_dmy(1, 2'd1, 0),
        mk_din(1, 2'd0, 2), 32'h0, -1);
    // R8: quad read longer than the buffer is cut to 512
    run(mk_main(1, 2'd0, 8'h6B, 0, 2'd0, 1, 0, 2'd0, 0), 32'h0, mk_din(1, 2'd2, 700), 32'h0, -1);
    // R7: write enabled with zero count is skipped; one address byte
    run(mk_main(1, 2'd0, 8'h02, 1, 2'd0, 1, 1, 2'd0, 0), 32'h0, mk_din(0, 2'd0, 5), 32'h0000007E, -1);
    // R10: start write during a running transaction
    run(mk_main(1, 2'd0, 8'hEB, 1, 2'd2, 3, 0, 2'd0, 0), mk_dmy(1, 2'd2, 4),
        mk_din(1, 2'd2, 6), 32'h00030201, 20);
    // R7: single-lane write with count 1023 is cut to 512
    run(mk_main(0, 2'd0, 8'h00, 0, 2'd0, 1, 1, 2'd0, 1023), 32'h0, 32'h0, 32'h0, -1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule